// File: doc/BRIEF.md
# Flash Busy Status Reporter

This block sits on the read path of a byte-wide parallel NOR flash model. An embedded program or erase engine elsewhere raises a busy flag for the length of the operation. While that flag is high, every read from the bus returns a status word instead of array contents, at any address. Bit 7 is a polling bit that shows whether the operation is still running. Bit 6 toggles from one read to the next. When busy drops, the array data passes through unchanged.

Software detects completion in one of two ways. It can compare the polling bit against the value it expects to see at the end. Or it can read twice and see whether bit 6 has stopped changing. A read access is the span in which chip enable and output enable are both asserted (active low). The access ends when either one is released, so toggling either strobe, or both, counts as a new read. The operation kind and the programmed byte are captured on the first busy cycle. The toggle state is also cleared on that cycle.

Top module: `flash_busy_status`

## Requirements
- R1: While busy with a program operation (erase flag 0 at start), output bit 7 is the inverse of bit 7 of the byte presented when busy rose.
- R2: While busy with an erase operation (erase flag 1 at start), output bit 7 reads 0.
- R3: While not busy, the output equals the array data input on all bits, so an erased array (FFh) reads with bit 7 at 1.
- R4: While busy, output bit 6 holds one value for the whole of a read access (ce_n and oe_n both low). It takes the opposite value from the clock after the access ends through either strobe going high.
- R5: On the first busy cycle of every new operation, output bit 6 reads 0, whatever state an earlier operation left behind.
- R6: While busy, all output bits other than 7 and 6 read 0.
- R7: Changes to the erase flag or to the program byte input after the first busy cycle have no effect on the status word.
- R8: With REG_OUT=1, the output equals the REG_OUT=0 result delayed by exactly one clock.
- R9: After reset, the registered variant outputs 0 and the toggle bit starts at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | High while an embedded operation runs |
| op_erase_i | input | 1 | 1 = erase, 0 = byte program; sampled on busy rise |
| load_byte_i | input | DATA_W | Last byte loaded for programming; sampled on busy rise |
| arr_data_i | input | DATA_W | Array read data |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rd_data_o | output | DATA_W | Read data or status word |

## Verification
The bench builds two instances side by side with DATA_W=8: one with REG_OUT=0 and one with REG_OUT=1. Both are compared against a single behavioural model, so any drift in the registered variant's one-clock delay shows up against the combinational result. The stimulus runs program and erase operations. It ends reads through ce_n alone, oe_n alone, and both together. It changes the operation inputs in the middle of a busy period, and it restarts an operation right after one that left bit 6 at 1.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
   typedef enum logic {
      OP_PROG  = 1'b0,
      OP_ERASE = 1'b1
   } op_kind_e;
endpackage

// File: rtl/fsr_read_detect.sv
module fsr_read_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic ce_n_i,
   input  logic oe_n_i,
   output logic rd_act_o,
   output logic rd_end_o
);
   logic rd_q;

   assign rd_act_o = ~ce_n_i & ~oe_n_i;

   always_ff @(posedge clk) begin
      if (!rst_n) rd_q <= 1'b0;
      else        rd_q <= rd_act_o;
   end

   // an access closes when either strobe is released
   assign rd_end_o = rd_q & ~rd_act_o;
endmodule

// File: rtl/fsr_status_gen.sv
module fsr_status_gen
   import flash_stat_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_erase_i,
   input  logic [DATA_W-1:0] load_byte_i,
   input  logic              rd_end_i,
   output logic [DATA_W-1:0] stat_o
);
   localparam int POLL_B = DATA_W - 1;
   localparam int TGL_B  = DATA_W - 2;

   logic              busy_q;
   logic              tgl_q;
   op_kind_e          kind_q;
   logic [DATA_W-1:0] byte_q;
   logic              start;
   op_kind_e          kind_c;
   logic [DATA_W-1:0] byte_c;
   logic              tgl_c;

   assign start = busy_i & ~busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         tgl_q  <= 1'b0;
         kind_q <= OP_PROG;
         byte_q <= '0;
      end else begin
         busy_q <= busy_i;
         if (start) begin
            tgl_q  <= 1'b0;
            kind_q <= op_kind_e'(op_erase_i);
            byte_q <= load_byte_i;
         end else if (busy_i && rd_end_i) begin
            tgl_q <= ~tgl_q;
         end
      end
   end

   always_comb begin
      kind_c = start ? op_kind_e'(op_erase_i) : kind_q;
      byte_c = start ? load_byte_i : byte_q;
      tgl_c  = start ? 1'b0 : tgl_q;
      stat_o = '0;
      stat_o[POLL_B] = (kind_c == OP_ERASE) ? 1'b0 : ~byte_c[POLL_B];
      stat_o[TGL_B]  = tgl_c;
   end
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status #(
   parameter int DATA_W  = 8,
   parameter int REG_OUT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic              op_erase_i,
   input  logic [DATA_W-1:0] load_byte_i,
   input  logic [DATA_W-1:0] arr_data_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   output logic [DATA_W-1:0] rd_data_o
);
   generate
      if (DATA_W < 3) begin : g_bad_width
         $error("flash_busy_status: DATA_W must be at least 3");
      end
      if (REG_OUT != 0 && REG_OUT != 1) begin : g_bad_reg
         $error("flash_busy_status: REG_OUT must be 0 or 1");
      end
   endgenerate

   logic              rd_act;
   logic              rd_end;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] sel_word;

   fsr_read_detect u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ce_n_i   (ce_n_i),
      .oe_n_i   (oe_n_i),
      .rd_act_o (rd_act),
      .rd_end_o (rd_end)
   );

   fsr_status_gen #(.DATA_W(DATA_W)) u_stat (
      .clk         (clk),
      .rst_n       (rst_n),
      .busy_i      (busy_i),
      .op_erase_i  (op_erase_i),
      .load_byte_i (load_byte_i),
      .rd_end_i    (rd_end),
      .stat_o      (stat_word)
   );

   assign sel_word = busy_i ? stat_word : arr_data_i;

   generate
      if (REG_OUT == 1) begin : g_reg
         logic [DATA_W-1:0] out_q;
         always_ff @(posedge clk) begin
            if (!rst_n) out_q <= '0;
            else        out_q <= sel_word;
         end
         assign rd_data_o = out_q;
      end else begin : g_comb
         assign rd_data_o = sel_word;
      end
   endgenerate
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk #(
   parameter int DATA_W  = 8,
   parameter int REG_OUT = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_i,
   input logic              op_erase_i,
   input logic [DATA_W-1:0] load_byte_i,
   input logic [DATA_W-1:0] arr_data_i,
   input logic              rd_act,
   input logic [DATA_W-1:0] stat_word,
   input logic [DATA_W-1:0] rd_data_o
);
   localparam int POLL_B = DATA_W - 1;
   localparam int TGL_B  = DATA_W - 2;
   localparam logic [DATA_W-1:0] LOW_MASK = {2'b00, {(DATA_W-2){1'b1}}};

   a_r1_prog_poll: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_i) && !op_erase_i) |-> stat_word[POLL_B] == ~load_byte_i[POLL_B]);

   a_r2_erase_poll: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy_i) && op_erase_i) |-> !stat_word[POLL_B]);

   a_r5_toggle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_i) |-> !stat_word[TGL_B]);

   a_r6_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> (stat_word & LOW_MASK) == '0);

   a_r4_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i) && rd_act && $past(rd_act)) |-> $stable(stat_word[TGL_B]));

   a_r7_kind_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && $past(busy_i)) |-> $stable(stat_word[POLL_B]));

   generate
      if (REG_OUT == 0) begin : g_comb_chk
         a_r3_idle_pass: assert property (@(posedge clk) disable iff (!rst_n)
            !busy_i |-> rd_data_o == arr_data_i);
      end else begin : g_reg_chk
         a_r8_delay: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> rd_data_o == $past(busy_i ? stat_word : arr_data_i));
      end
   endgenerate
endmodule

bind flash_busy_status flash_busy_status_chk #(.DATA_W(DATA_W), .REG_OUT(REG_OUT)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_i      (busy_i),
   .op_erase_i  (op_erase_i),
   .load_byte_i (load_byte_i),
   .arr_data_i  (arr_data_i),
   .rd_act      (rd_act),
   .stat_word   (stat_word),
   .rd_data_o   (rd_data_o)
);

// File: tb/flash_busy_status_test.sv
`timescale 1ns/1ps
module flash_busy_status_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         busy = 1'b0;
   logic         erase = 1'b0;
   logic [W-1:0] lbyte = '0;
   logic [W-1:0] arr = '0;
   logic         ce_n = 1'b1;
   logic         oe_n = 1'b1;
   logic [W-1:0] dout_c;
   logic [W-1:0] dout_r;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   // reference model state
   bit           m_busy_q = 0;
   bit           m_rd_q = 0;
   bit           m_tgl = 0;
   bit           m_kind = 0;
   logic [W-1:0] m_byte = '0;
   logic [W-1:0] exp_prev = '0;

   always #2.5 clk = ~clk;

   flash_busy_status #(.DATA_W(W), .REG_OUT(0)) uut (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(erase),
      .load_byte_i(lbyte), .arr_data_i(arr), .ce_n_i(ce_n), .oe_n_i(oe_n),
      .rd_data_o(dout_c));

   flash_busy_status #(.DATA_W(W), .REG_OUT(1)) uut_reg (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .op_erase_i(erase),
      .load_byte_i(lbyte), .arr_data_i(arr), .ce_n_i(ce_n), .oe_n_i(oe_n),
      .rd_data_o(dout_r));

   task automatic chk(input string tag, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   // one clock: inputs already driven at this negedge; check, then advance model
   task automatic tick();
      bit           rise;
      bit           kind_c;
      bit           tgl_c;
      bit           rd_now;
      logic [W-1:0] byte_c;
      logic [W-1:0] exp;
      #1;
      rise   = busy && !m_busy_q;
      kind_c = rise ? erase : m_kind;
      byte_c = rise ? lbyte : m_byte;
      tgl_c  = rise ? 1'b0 : m_tgl;
      rd_now = !ce_n && !oe_n;
      if (busy) begin
         exp = '0;
         exp[7] = kind_c ? 1'b0 : ~byte_c[7];
         exp[6] = tgl_c;
         if (kind_c) chk("R2 erase poll bit", dout_c[7], exp[7]);
         else        chk("R1 program poll bit", dout_c[7], exp[7]);
         chk("R4 toggle bit", dout_c[6], exp[6]);
         chk("R6 low bits zero", dout_c[5:0], 0);
      end else begin
         exp = arr;
         chk("R3 idle pass-through", dout_c, exp);
      end
      chk("R8 registered delay", dout_r, exp_prev);
      exp_prev = rst_n ? exp : '0;
      if (rst_n) begin
         if (rise) begin
            m_tgl = 0; m_kind = erase; m_byte = lbyte;
         end else if (busy && m_rd_q && !rd_now) begin
            m_tgl = ~m_tgl;
         end
         m_busy_q = busy;
         m_rd_q = rd_now;
      end
      @(negedge clk);
   endtask

   // read access: strobes low for nlow clocks, then released per mode
   // mode 0: both released, 1: only ce_n, 2: only oe_n
   task automatic rd(input int nlow, input int mode);
      ce_n = 1'b0; oe_n = 1'b0;
      for (int i = 0; i < nlow; i++) tick();
      if (mode == 0) begin ce_n = 1'b1; oe_n = 1'b1; end
      else if (mode == 1) ce_n = 1'b1;
      else oe_n = 1'b1;
      tick();
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      for (int i = 0; i < 3; i++) tick();
      // R9: registered output is zero out of reset
      chk("R9 reset output", dout_r, 0);
      rst_n = 1'b1;

      // R3: idle reads follow the array
      arr = 8'h5A; rd(2, 0);
      arr = 8'h3C; rd(1, 0);

      // program of 0x35 (bit7 = 0 -> poll reads 1); R5 first read sees 0
      lbyte = 8'h35; erase = 1'b0; busy = 1'b1; arr = 8'h77;
      tick();
      rd(3, 0);
      // R7: operation inputs change mid-busy, status must not follow
      lbyte = 8'hFF; erase = 1'b1;
      rd(2, 1);
      rd(1, 2);
      tick();
      busy = 1'b0; arr = 8'h35; tick(); rd(1, 0);

      // program of 0xC4 (poll reads 0); reads ended by each strobe
      lbyte = 8'hC4; erase = 1'b0; busy = 1'b1;
      rd(1, 2); rd(2, 1); rd(1, 0);
      // R5: drop busy with toggle at 1, restart at once as erase
      busy = 1'b0; arr = 8'hC4; tick();
      erase = 1'b1; lbyte = 8'h00; busy = 1'b1;
      rd(2, 0); rd(1, 1); rd(1, 2);
      // R2 then R3: erase finishes, array reads FFh so bit 7 is 1
      busy = 1'b0; arr = 8'hFF; rd(1, 0); tick();

      // long erase with many reads
      erase = 1'b1; busy = 1'b1;
      for (int k = 0; k < 20; k++) rd(1 + (k % 3), k % 3);
      busy = 1'b0; arr = 8'hA5; tick(); tick();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule